// File: doc/BRIEF.md
# UART Receive Status Flag Controller

This block holds the received data register of a UART receiver together with its four status flags: data ready, idle line, overrun and noise. It also produces the receive interrupt request. The bit sampler delivers a one-cycle word-complete pulse with the received byte and a noise indication. The idle detector delivers a one-cycle idle pulse. The processor bus delivers one-cycle read strobes for the status register and the data register. Baud generation, oversampling and the detection logic itself are outside the block.

The data-ready flag follows each transfer into the data register and is cleared by a data read. The idle, overrun and noise flags are sticky. They are removed only by a status read followed by a data read, and only those flags that were visible at the status read are removed. When a word arrives while the previous one is still unread, the old word stays in the data register and the new one is dropped. After the idle flag has set once, it re-arms only when a new word is loaded.

The interrupt request is a level. It is the OR of every flag condition whose enable is set. Overrun and noise can also interrupt through the error enable, but only in multi-buffer mode.

Top module: `uart_rx_status`

## Requirements
- R1: After reset the status register reads 0x00, the data register reads 0x00 and the interrupt request is low.
- R2: A word-complete pulse while data-ready is 0 loads the byte into the data register and sets status bit 5 (data ready) on the next clock edge.
- R3: A data register read clears status bit 5 on the next clock edge, unless a word completes in the same cycle.
- R4: A word-complete pulse while bit 5 is 1 and no data read is in progress sets status bit 3 (overrun). The data register keeps its old byte.
- R5: When a word completes in the same cycle as a data read, the new byte loads, bit 5 stays 1 and bit 3 is not set.
- R6: An idle pulse sets status bit 4 (idle). Once bit 4 has set, later idle pulses have no effect until a new word has been loaded into the data register.
- R7: A word loaded with its noise indication high sets status bit 2 (noise).
- R8: A status read followed later by a data read clears those of bits 4, 3 and 2 that were set at the status read.
- R9: A data read with no status read since the previous data read leaves bits 4, 3 and 2 unchanged.
- R10: A flag that sets after the status read is not cleared by the data read that completes the sequence.
- R11: The interrupt request is high while (bit 5 or bit 3) is set with the data-ready enable, or while bit 4 is set with the idle enable.
- R12: With the error enable set, bits 3 and 2 raise the interrupt only in multi-buffer mode. Outside that mode, noise alone never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_done | input | 1 | One-cycle pulse: a received word is complete in the shift register |
| word_data | input | 8 | Byte carried by the completed word |
| word_noise | input | 1 | Noise was seen during the completed word |
| idle_seen | input | 1 | One-cycle pulse: idle line detected |
| rd_status | input | 1 | Bus read strobe of the status register |
| rd_data | input | 1 | Bus read strobe of the data register |
| rdy_ie | input | 1 | Data-ready/overrun interrupt enable |
| idle_ie | input | 1 | Idle interrupt enable |
| err_ie | input | 1 | Error interrupt enable (multi-buffer mode) |
| multi_buf | input | 1 | Multi-buffer (DMA) mode select |
| rx_data | output | 8 | Data register contents |
| status | output | 8 | Status register: bit 5 ready, 4 idle, 3 overrun, 2 noise, others 0 |
| irq | output | 1 | Receive interrupt request (level) |

## Verification
The hardest situation to reach is a flag that sets inside an open clear sequence. It needs a status read, then a new event, then the data read, with each step in its own cycle. The bench performs the status read first and then sends an idle pulse. That pulse only works if a fresh word has re-armed the idle flag earlier. The data read follows, and the bench checks that the noise and ready bits are gone while the idle bit remains. The same-cycle collision of a word and a data read is driven as one combined strobe cycle after the register has been filled.

// File: rtl/uart_rx_status_pkg.sv
// Package: shared widths and status bit positions of the receive status block.
// Assumes: an 8-bit status register, whose layout is decoded by software.
package uart_rx_status_pkg;
    localparam int STAT_W   = 8;
    localparam int BIT_RDY  = 5;
    localparam int BIT_IDLE = 4;
    localparam int BIT_OVR  = 3;
    localparam int BIT_NSE  = 2;

    typedef struct packed {
        logic idle;
        logic ovr;
        logic noise;
    } sticky_t;
endpackage

// File: rtl/rx_data_hold.sv
// Module: rx_data_hold
// Holds the data register and the data-ready flag. It decides, for each
// completed word, whether the word loads or is an overrun.
// Assumes: word_done and rd_data are single-cycle strobes. A read in the
// same cycle as a word frees the register first.
module rx_data_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_done_i,
    input  logic [DATA_W-1:0] word_data_i,
    input  logic              rd_data_i,
    output logic              ready_o,
    output logic [DATA_W-1:0] data_o,
    output logic              load_o,
    output logic              ovr_evt_o
);
    logic              ready_q;
    logic [DATA_W-1:0] data_q;

    // Classify the completed word: load if the register is free (or freed now).
    always_comb begin
        load_o    = word_done_i && (!ready_q || rd_data_i);
        ovr_evt_o = word_done_i && ready_q && !rd_data_i;
    end

    // Data register and ready flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
            data_q  <= '0;
        end else begin
            if (load_o) begin
                data_q  <= word_data_i;
                ready_q <= 1'b1;
            end else if (rd_data_i) begin
                ready_q <= 1'b0;
            end
        end
    end

    assign ready_o = ready_q;
    assign data_o  = data_q;

    // R4: an overrun leaves the held byte untouched
    p_keep_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done_i && ready_q && !rd_data_i) |=> (data_q == $past(data_q)));

    // R3: a plain data read empties the register
    p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_i && !word_done_i) |=> !ready_q);

    // R5: collision of read and new word keeps ready high
    p_collide_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_i && word_done_i) |=> (ready_q && data_q == $past(word_data_i)));
endmodule

// File: rtl/rx_sticky_flags.sv
// Module: rx_sticky_flags
// Holds the idle, overrun and noise flags and the two-step clear sequence.
// A status read takes a snapshot of the flags it saw. The next data read
// clears exactly that snapshot. A flag that sets in the same cycle wins over
// the clear. Once idle has set, it is blocked until a new word loads.
// Assumes: all inputs are single-cycle strobes.
module rx_sticky_flags
    import uart_rx_status_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load_i,
    input  logic    noise_i,
    input  logic    ovr_evt_i,
    input  logic    idle_seen_i,
    input  logic    rd_status_i,
    input  logic    rd_data_i,
    output sticky_t flags_o
);
    sticky_t flags_q;
    sticky_t snap_q;
    logic    idle_block_q;
    sticky_t set_v;
    sticky_t clr_v;

    // Set and clear requests for this cycle.
    always_comb begin
        set_v.idle  = idle_seen_i && !idle_block_q;
        set_v.ovr   = ovr_evt_i;
        set_v.noise = load_i && noise_i;
        clr_v       = rd_data_i ? snap_q : '0;
    end

    // Flag registers: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= set_v | (flags_q & ~clr_v);
        end
    end

    // Clear snapshot: taken by a status read, consumed by a data read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (rd_status_i) begin
            snap_q <= flags_q;
        end else if (rd_data_i) begin
            snap_q <= '0;
        end
    end

    // Idle re-arm: block after idle sets, release on a newly loaded word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_block_q <= 1'b0;
        end else if (set_v.idle) begin
            idle_block_q <= 1'b1;
        end else if (load_i) begin
            idle_block_q <= 1'b0;
        end
    end

    assign flags_o = flags_q;

    // R6: while blocked, a clear idle flag stays clear
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_block_q && !flags_q.idle) |=> !flags_q.idle);

    // R9: a data read without an armed snapshot removes no sticky flag
    p_unarmed_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_i && snap_q == '0) |=>
            (!$fell(flags_q.idle) && !$fell(flags_q.ovr) && !$fell(flags_q.noise)));

    // R10: an overrun raised during the sequence survives its data read
    p_late_ovr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_i && !snap_q.ovr && flags_q.ovr) |=> flags_q.ovr);
endmodule

// File: rtl/rx_irq_merge.sv
// Module: rx_irq_merge
// Combines the flags with their enables into one level interrupt request.
// Overrun and noise reach the error enable only in multi-buffer mode.
// Assumes: flags come from registers, so the output has no timing loop.
module rx_irq_merge (
    input  logic clk,
    input  logic rst_n,
    input  logic ready_i,
    input  logic idle_i,
    input  logic ovr_i,
    input  logic noise_i,
    input  logic rdy_ie_i,
    input  logic idle_ie_i,
    input  logic err_ie_i,
    input  logic multi_buf_i,
    output logic irq_o
);
    logic main_req;
    logic err_req;

    // Request terms: data path, idle, and multi-buffer error path.
    always_comb begin
        main_req = (rdy_ie_i && (ready_i || ovr_i)) || (idle_ie_i && idle_i);
        err_req  = multi_buf_i && err_ie_i && (ovr_i || noise_i);
        irq_o    = main_req || err_req;
    end

    // R12: outside multi-buffer mode, noise alone never requests
    p_noise_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!multi_buf_i && noise_i && !ready_i && !idle_i && !ovr_i) |-> !irq_o);
endmodule

// File: rtl/uart_rx_status.sv
// Module: uart_rx_status (top)
// Receive-side data register, status flags and interrupt request of a UART.
// Assumes: strobes from the sampler, the idle detector and the bus are
// single-cycle and synchronous to clk.
module uart_rx_status
    import uart_rx_status_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_done,
    input  logic [DATA_W-1:0] word_data,
    input  logic              word_noise,
    input  logic              idle_seen,
    input  logic              rd_status,
    input  logic              rd_data,
    input  logic              rdy_ie,
    input  logic              idle_ie,
    input  logic              err_ie,
    input  logic              multi_buf,
    output logic [DATA_W-1:0] rx_data,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    logic    ready;
    logic    load;
    logic    ovr_evt;
    sticky_t flags;

    rx_data_hold #(.DATA_W(DATA_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_done_i (word_done),
        .word_data_i (word_data),
        .rd_data_i   (rd_data),
        .ready_o     (ready),
        .data_o      (rx_data),
        .load_o      (load),
        .ovr_evt_o   (ovr_evt)
    );

    rx_sticky_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .noise_i     (word_noise),
        .ovr_evt_i   (ovr_evt),
        .idle_seen_i (idle_seen),
        .rd_status_i (rd_status),
        .rd_data_i   (rd_data),
        .flags_o     (flags)
    );

    rx_irq_merge u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ready_i     (ready),
        .idle_i      (flags.idle),
        .ovr_i       (flags.ovr),
        .noise_i     (flags.noise),
        .rdy_ie_i    (rdy_ie),
        .idle_ie_i   (idle_ie),
        .err_ie_i    (err_ie),
        .multi_buf_i (multi_buf),
        .irq_o       (irq)
    );

    // Status register layout.
    always_comb begin
        status           = '0;
        status[BIT_RDY]  = ready;
        status[BIT_IDLE] = flags.idle;
        status[BIT_OVR]  = flags.ovr;
        status[BIT_NSE]  = flags.noise;
    end

    // R11: an enabled ready flag always requests
    p_ready_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (status[BIT_RDY] && rdy_ie) |-> irq);
endmodule

// File: tb/uart_rx_status_test.sv
module uart_rx_status_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       word_done = 1'b0;
    logic [7:0] word_data = '0;
    logic       word_noise = 1'b0;
    logic       idle_seen = 1'b0;
    logic       rd_status = 1'b0;
    logic       rd_data = 1'b0;
    logic       rdy_ie = 1'b0;
    logic       idle_ie = 1'b0;
    logic       err_ie = 1'b0;
    logic       multi_buf = 1'b0;
    logic [7:0] rx_data;
    logic [7:0] status;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    uart_rx_status uut (
        .clk(clk), .rst_n(rst_n), .word_done(word_done), .word_data(word_data),
        .word_noise(word_noise), .idle_seen(idle_seen), .rd_status(rd_status),
        .rd_data(rd_data), .rdy_ie(rdy_ie), .idle_ie(idle_ie), .err_ie(err_ie),
        .multi_buf(multi_buf), .rx_data(rx_data), .status(status), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // One strobe cycle: drive at negedge, release at the following negedge.
    task automatic strobe(input bit wd, input logic [7:0] d, input bit nz,
                          input bit idl, input bit rs, input bit rdd);
        word_done = wd; word_data = d; word_noise = nz;
        idle_seen = idl; rd_status = rs; rd_data = rdd;
        @(negedge clk);
        word_done = 0; word_noise = 0; idle_seen = 0; rd_status = 0; rd_data = 0;
    endtask

    task automatic t_reset();
        check("R1 status", status, 8'h00);
        check("R1 data", rx_data, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_load_read();
        rdy_ie = 1;
        strobe(1, 8'hA5, 0, 0, 0, 0);
        check("R2 status", status, 8'h20);
        check("R2 data", rx_data, 8'hA5);
        check("R11 ready irq", {7'd0, irq}, 8'h01);
        strobe(0, 0, 0, 0, 0, 1);
        check("R3 status", status, 8'h00);
        check("R11 irq low", {7'd0, irq}, 8'h00);
        rdy_ie = 0;
    endtask

    task automatic t_overrun();
        strobe(1, 8'h11, 0, 0, 0, 0);
        strobe(1, 8'h22, 0, 0, 0, 0);
        check("R4 status", status, 8'h28);
        check("R4 data kept", rx_data, 8'h11);
        rdy_ie = 1; #1;
        strobe(0, 0, 0, 0, 0, 1);
        check("R9 unarmed read", status, 8'h08);
        check("R11 ovr irq", {7'd0, irq}, 8'h01);
        rdy_ie = 0;
        strobe(0, 0, 0, 0, 1, 0);
        strobe(0, 0, 0, 0, 0, 1);
        check("R8 clear seq", status, 8'h00);
    endtask

    task automatic t_collide();
        strobe(1, 8'h33, 0, 0, 0, 0);
        strobe(1, 8'h44, 0, 0, 0, 1);
        check("R5 status", status, 8'h20);
        check("R5 data", rx_data, 8'h44);
        strobe(0, 0, 0, 0, 0, 1);
        check("R3 after collide", status, 8'h00);
    endtask

    task automatic t_idle();
        idle_ie = 1;
        strobe(0, 0, 0, 1, 0, 0);
        check("R6 idle set", status, 8'h10);
        check("R11 idle irq", {7'd0, irq}, 8'h01);
        strobe(0, 0, 0, 0, 1, 0);
        strobe(0, 0, 0, 0, 0, 1);
        check("R8 idle cleared", status, 8'h00);
        strobe(0, 0, 0, 1, 0, 0);
        check("R6 no rearm", status, 8'h00);
        strobe(1, 8'h55, 0, 0, 0, 0);
        strobe(0, 0, 0, 0, 0, 1);
        strobe(0, 0, 0, 1, 0, 0);
        check("R6 rearmed", status, 8'h10);
        strobe(0, 0, 0, 0, 1, 0);
        strobe(0, 0, 0, 0, 0, 1);
        check("R8 idle cleared again", status, 8'h00);
        idle_ie = 0;
    endtask

    task automatic t_noise();
        strobe(1, 8'h66, 1, 0, 0, 0);
        check("R7 noise", status, 8'h24);
        err_ie = 1; #1;
        check("R12 single mode quiet", {7'd0, irq}, 8'h00);
        multi_buf = 1; #1;
        check("R12 multi mode irq", {7'd0, irq}, 8'h01);
        multi_buf = 0; err_ie = 0;
        strobe(0, 0, 0, 0, 1, 0);
        strobe(0, 0, 0, 1, 0, 0);
        strobe(0, 0, 0, 0, 0, 1);
        check("R10 late idle kept", status, 8'h10);
        strobe(0, 0, 0, 0, 1, 0);
        strobe(0, 0, 0, 0, 0, 1);
        check("R8 final clear", status, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_load_read();
        t_overrun();
        t_collide();
        t_idle();
        t_noise();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule